// File: doc/BRIEF.md
# Real-Time Clock Register Block with Deferred Write Commit

This block is a memory-mapped real-time clock. It keeps time in two 32-bit counters: a seconds count and a fraction count below it. The fraction count advances on a tick-enable input, and each time it wraps it carries into the seconds count. A pair of alarm registers is compared with the running time, and a match raises a sticky alarm flag. Software reaches the block through a plain 32-bit register port with a word address, a write enable, write data and combinational read data.

Register writes are not applied at once. An accepted write is held pending with a busy flag high for a fixed number of cycles, then committed. The commit sets a "write complete" flag and a "ready for next write" flag. A write that arrives while another is still pending is discarded and raises a write-error flag. Software polls these flags before it issues the next write. The time counter stays frozen until its seconds register has been committed at least once after reset, even when the enable bit is set. One interrupt output combines the status flags with a matching enable mask.

Register map by word address: 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 control, 5 status, 6 interrupt enable. Address 7 reads zero and ignores writes.

Top module: `rtc_regblock`

## Requirements
- R1: After reset the status register reads 0x00000002 (non-valid bit 1 set, all other flags clear), seconds, fraction, control, alarm fraction and interrupt enable read 0, alarm seconds reads 0xFFFFFFFF, and irq is low.
- R2: An accepted write keeps status bit 10 (busy) high and the target register unchanged for WR_DELAY (default 4) cycles. The write then commits: the new value becomes readable, busy drops, and status bit 8 (write complete) and bit 9 (ready for next) are set.
- R3: A write presented while busy is high is discarded, its target keeps its old value, and status bit 7 (write error) is set.
- R4: The time counter does not advance before a write to the seconds register (address 0) has committed after reset, even with control bit 3 set and tick high.
- R5: Once seconds has been written, each cycle with control bit 3 set and tick high adds one to the fraction register. With tick low, or with control bit 3 clear, the time holds.
- R6: When the fraction register steps from 0xFFFFFFFF to 0, the seconds register increments by one in the same cycle.
- R7: Status bit 4 (alarm) is set when the seconds and fraction values equal alarm seconds and alarm fraction. It stays set after the time moves on, until it is cleared.
- R8: A committed write to status clears each of bits 9, 8, 7 and 4 that is written as 1, and bits written as 0 keep their state. The commit's own complete and next flags are set after the clear is applied.
- R9: Non-valid (bit 1) and violation (bit 0) clear only when a committed status write has both bits 1 and 0 set. Writing bit 1 alone leaves non-valid set.
- R10: The interrupt enable register keeps only bits 9, 8, 7 and 4, and the other bits read 0. irq is high exactly when some status bit among 9, 8, 7 and 4 is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Fraction count enable pulse |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write request |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The write path is tried with isolated writes, where busy is sampled mid-flight and the value after the commit, and with back-to-back writes, which separate a discarded write from an accepted one through the target register and the error flag. Tick bursts are applied before the seconds register is ever written, after it is written, across a fraction wrap and with the enable bit cleared. These cases tell the frozen-until-written rule, the carry and the enable hold apart. The status writes differ in which bits they set, so plain one-to-clear is separated from the paired valid-state clear, and two interrupt masks show that irq follows only the enabled flags.

// File: rtl/rtc_regblock.sv
module rtc_regblock #(
  parameter int WR_DELAY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int          CW       = $clog2(WR_DELAY + 1);
  localparam logic [31:0] IRQ_MASK = 32'h0000_0390;

  logic [CW-1:0] wait_q;
  logic [2:0]    pend_addr;
  logic [31:0]   pend_data;
  logic [31:0]   sec_q, frac_q, asec_q, afrac_q, ctrl_q, ier_q;
  logic          nxt_f, done_f, err_f, alm_f, inval_f, viol_f, seeded;
  logic [31:0]   status, clr;

  wire busy   = (wait_q != '0);
  wire accept = wr_en && !busy;
  wire drop   = wr_en && busy;
  wire commit = (wait_q == CW'(1));
  wire match  = (sec_q == asec_q) && (frac_q == afrac_q);
  wire run    = ctrl_q[3] && seeded && tick;

  assign clr    = (commit && pend_addr == 3'd5) ? pend_data : 32'h0;
  assign status = {21'h0, busy, nxt_f, done_f, err_f, 2'b00, alm_f, 2'b00, inval_f, viol_f};
  assign irq    = |(status & ier_q);

  always_comb begin
    case (addr)
      3'd0:    rdata = sec_q;
      3'd1:    rdata = frac_q;
      3'd2:    rdata = asec_q;
      3'd3:    rdata = afrac_q;
      3'd4:    rdata = ctrl_q;
      3'd5:    rdata = status;
      3'd6:    rdata = ier_q;
      default: rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q    <= '0;
      pend_addr <= '0;
      pend_data <= '0;
    end else if (accept) begin
      wait_q    <= CW'(WR_DELAY);
      pend_addr <= addr;
      pend_data <= wdata;
    end else if (busy) begin
      wait_q <= wait_q - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q   <= '0;
      frac_q  <= '0;
      asec_q  <= 32'hFFFF_FFFF;
      afrac_q <= '0;
      ctrl_q  <= '0;
      ier_q   <= '0;
      seeded  <= 1'b0;
    end else begin
      if (commit && pend_addr == 3'd0) begin
        sec_q  <= pend_data;
        seeded <= 1'b1;
      end else if (commit && pend_addr == 3'd1) begin
        frac_q <= pend_data;
      end else if (run) begin
        frac_q <= frac_q + 32'd1;
        if (&frac_q) sec_q <= sec_q + 32'd1;
      end
      if (commit) begin
        case (pend_addr)
          3'd2:    asec_q  <= pend_data;
          3'd3:    afrac_q <= pend_data;
          3'd4:    ctrl_q  <= pend_data;
          3'd6:    ier_q   <= pend_data & IRQ_MASK;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_f   <= 1'b0;
      done_f  <= 1'b0;
      err_f   <= 1'b0;
      alm_f   <= 1'b0;
      inval_f <= 1'b1;
      viol_f  <= 1'b0;
    end else begin
      nxt_f  <= (nxt_f & ~clr[9] & ~accept) | commit;
      done_f <= (done_f & ~clr[8]) | commit;
      err_f  <= (err_f & ~clr[7]) | drop;
      alm_f  <= (alm_f & ~clr[4]) | match;
      if (clr[1] && clr[0]) begin
        inval_f <= 1'b0;
        viol_f  <= 1'b0;
      end
    end
  end

  // R2
  commit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_f && nxt_f));
  // R3
  drop_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> err_f);
  // R4
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seeded && !(commit && pend_addr == 3'd1)) |=> $stable(frac_q));
  // R6
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !commit && &frac_q) |=> (frac_q == 32'd0 && sec_q == $past(sec_q) + 32'd1));
  // R7
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> alm_f);
  // R10
  ier_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q & ~IRQ_MASK) == 32'h0);
endmodule

// File: tb/rtc_regblock_test.sv
module rtc_regblock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  rtc_regblock uut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
                    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {31'h0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1; it.exp = {31'h0, e}; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic put(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic put_wait(input logic [2:0] a, input logic [31:0] d);
    put(a, d);
    repeat (6) @(posedge clk);
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    expect_reg(3'd5, 32'h0000_0002, "R1 status");
    expect_reg(3'd0, 32'h0, "R1 seconds");
    expect_reg(3'd1, 32'h0, "R1 fraction");
    expect_reg(3'd2, 32'hFFFF_FFFF, "R1 alarm seconds");
    expect_reg(3'd3, 32'h0, "R1 alarm fraction");
    expect_reg(3'd4, 32'h0, "R1 control");
    expect_reg(3'd6, 32'h0, "R1 irq enable");
    expect_irq(1'b0, "R1 irq");

    put(3'd4, 32'h8);
    expect_reg(3'd5, 32'h0000_0402, "R2 busy during pending");
    repeat (6) @(posedge clk);
    expect_reg(3'd4, 32'h8, "R2 control committed");
    expect_reg(3'd5, 32'h0000_0302, "R2 complete and next");

    ticks(10);
    expect_reg(3'd1, 32'h0, "R4 fraction frozen");
    expect_reg(3'd0, 32'h0, "R4 seconds frozen");

    put(3'd1, 32'h100);
    put(3'd4, 32'h0);
    repeat (6) @(posedge clk);
    expect_reg(3'd4, 32'h8, "R3 dropped write target");
    expect_reg(3'd1, 32'h100, "R3 first write kept");
    expect_reg(3'd5, 32'h0000_0382, "R3 error flag");

    put_wait(3'd5, 32'h80);
    expect_reg(3'd5, 32'h0000_0302, "R8 error cleared");

    ticks(4);
    expect_reg(3'd1, 32'h100, "R4 frozen after fraction write");

    put_wait(3'd0, 32'd5);
    ticks(3);
    expect_reg(3'd1, 32'h103, "R5 fraction counts");
    repeat (3) @(posedge clk);
    expect_reg(3'd1, 32'h103, "R5 hold without tick");
    expect_reg(3'd0, 32'd5, "R5 seconds unchanged");

    put_wait(3'd1, 32'hFFFF_FFFE);
    ticks(3);
    expect_reg(3'd0, 32'd6, "R6 carry into seconds");
    expect_reg(3'd1, 32'd1, "R6 fraction after wrap");

    put_wait(3'd4, 32'h0);
    ticks(4);
    expect_reg(3'd1, 32'd1, "R5 hold with enable clear");

    put_wait(3'd2, 32'd6);
    put_wait(3'd3, 32'd4);
    expect_reg(3'd5, 32'h0000_0302, "R7 no alarm before match");
    put_wait(3'd4, 32'h8);
    ticks(3);
    expect_reg(3'd5, 32'h0000_0312, "R7 alarm set");
    ticks(2);
    expect_reg(3'd5, 32'h0000_0312, "R7 alarm sticky");
    put_wait(3'd5, 32'h0);
    expect_reg(3'd5, 32'h0000_0312, "R8 zero write keeps flags");
    put_wait(3'd5, 32'h10);
    expect_reg(3'd5, 32'h0000_0302, "R8 alarm cleared");

    put_wait(3'd6, 32'hFFFF_FFFF);
    expect_reg(3'd6, 32'h0000_0390, "R10 enable mask");
    expect_irq(1'b1, "R10 irq from complete");
    put_wait(3'd6, 32'h10);
    expect_irq(1'b0, "R10 irq masked");
    put_wait(3'd3, 32'd8);
    ticks(2);
    expect_irq(1'b1, "R10 irq from alarm");

    put_wait(3'd5, 32'h2);
    expect_reg(3'd5, 32'h0000_0312, "R9 single bit keeps non-valid");
    put_wait(3'd5, 32'h3);
    expect_reg(3'd5, 32'h0000_0310, "R9 pair clears non-valid");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule